// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the command-handling slice of a serial flash that serves three one-byte instructions over a mode-0 SPI slave port. The instructions are write-enable, read-status and write-status. The SPI pins are oversampled in the system clock domain through a configurable synchronizer. Input bits are taken on the rising serial clock and output bits change on the falling serial clock. The block keeps the protection fields of the status register: two block-protect bits and a lock bit. It also keeps a write-enable latch and a busy flag.

A status write is committed only when four conditions all hold. The latch must be set, the frame must end exactly after the data byte, the part must not be hardware-protected, and no earlier write may still be running. A committed write starts a self-timed busy period whose length in system clocks is a parameter. During that period the status byte can still be read back. Opcodes are 06h (write enable), 05h (read status) and 01h (write status), all sent MSB first.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, write_busy, wr_enabled, blk_prot and sr_lock are all 0, and spi_dout is 0.
- R2: A frame holding exactly the byte 06h (select rises right after its eighth bit) sets wr_enabled when select rises. A 06h frame carrying any further bit leaves wr_enabled unchanged.
- R3: A write-status frame committed while wr_enabled is 0 leaves sr_lock and blk_prot unchanged.
- R4: A write-status frame (01h, then one data byte) commits only if select rises right after the eighth data bit. Frames with fewer or more data bits change neither the status fields nor wr_enabled.
- R5: A commit loads sr_lock from data bit 7, blk_prot[1] from data bit 3 and blk_prot[0] from data bit 2. Data bits 6, 5, 4, 1 and 0 have no effect.
- R6: A commit clears wr_enabled and holds write_busy at 1 for WRITE_CYCLES system clocks, after which write_busy returns to 0.
- R7: After opcode 05h, spi_dout presents the status byte {sr_lock, 0, 0, 0, blk_prot[1], blk_prot[0], wr_enabled, write_busy}. The byte goes out MSB first, each bit changing after a falling serial clock. It repeats for as long as select stays low, including while write_busy is 1.
- R8: While sr_lock is 1 and wr_guard_n is 0, write-status frames are ignored: the status fields and wr_enabled keep their values.
- R9: A first byte other than 06h, 05h or 01h makes the rest of the frame ignored until select goes high, even if a valid opcode follows.
- R10: While write_busy is 1, write-enable and write-status frames have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sel_n | input | 1 | Active-low chip select |
| spi_clk | input | 1 | Serial clock, mode 0 |
| spi_din | input | 1 | Serial data in, MSB first |
| wr_guard_n | input | 1 | Active-low write-protect pin |
| spi_dout | output | 1 | Serial data out, 0 when deselected |
| write_busy | output | 1 | Self-timed write cycle in progress |
| wr_enabled | output | 1 | Write-enable latch |
| blk_prot | output | 2 | Block-protect bits |
| sr_lock | output | 1 | Status-register write-disable bit |

## Verification
The assertions assume that the SPI pins change slowly against the system clock. Each serial clock level and each select transition must last longer than the synchronizer depth plus one cycle, so that every edge is seen exactly once. They also assume that wr_guard_n is steady around a select rise. The stimulus keeps every serial clock half period at eight system clocks. It lets several clocks pass between select edges and the serial clock, and it changes the protect pin only while select is high and no frame is pending.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   localparam int BYTE_W = 8;
   localparam int IDX_W  = $clog2(BYTE_W);

   localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;
   localparam logic [BYTE_W-1:0] OPC_RDSR = 8'h05;
   localparam logic [BYTE_W-1:0] OPC_WRSR = 8'h01;

   localparam int POS_LOCK = 7;
   localparam int POS_BP1  = 3;
   localparam int POS_BP0  = 2;
   localparam int POS_WEL  = 1;
   localparam int POS_BUSY = 0;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_WEN_TAIL,
      PH_STAT_DATA,
      PH_STAT_TAIL,
      PH_READOUT,
      PH_DISCARD
   } phase_t;

   typedef struct packed {
      logic       lock;
      logic [1:0] bp;
   } prot_t;

endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (STAGES >= 1 && STAGES <= 4)
         else $error("fsp_sync: STAGES must be in 1..4");
      assert (WIDTH >= 1)
         else $error("fsp_sync: WIDTH must be positive");
   end

   generate
      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= RST_VAL;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/fsp_frame.sv
module fsp_frame
   import fsp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_s,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic [BYTE_W-1:0] status_byte,
   output logic              dout,
   output logic              sel_rise,
   output logic              wren_req,
   output logic              wrsr_req,
   output logic [BYTE_W-1:0] wrsr_data
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

   logic              sclk_q;
   logic              sel_q;
   logic              sclk_rise;
   logic              sclk_fall;
   logic [IDX_W-1:0]  bit_idx;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] byte_in;
   logic              byte_done;
   logic [BYTE_W-1:0] data_q;
   logic [BYTE_W-1:0] snap;
   logic              dout_q;
   phase_t            phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         sel_q  <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         sel_q  <= sel_n_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_q & ~sel_n_s;
   assign sclk_fall = ~sclk_s & sclk_q & ~sel_n_s;
   assign sel_rise  = sel_n_s & ~sel_q;
   assign byte_in   = {shreg[BYTE_W-2:0], din_s};
   assign byte_done = sclk_rise && (bit_idx == LAST_IDX);

   // receive shifter and phase tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
         shreg   <= '0;
         data_q  <= '0;
         phase   <= PH_OPCODE;
      end else if (sel_n_s) begin
         bit_idx <= '0;
         phase   <= PH_OPCODE;
      end else if (sclk_rise) begin
         shreg   <= byte_in;
         bit_idx <= bit_idx + 1'b1;
         unique case (phase)
            PH_OPCODE: begin
               if (byte_done) begin
                  if (byte_in == OPC_WREN)      phase <= PH_WEN_TAIL;
                  else if (byte_in == OPC_RDSR) phase <= PH_READOUT;
                  else if (byte_in == OPC_WRSR) phase <= PH_STAT_DATA;
                  else                          phase <= PH_DISCARD;
               end
            end
            PH_STAT_DATA: begin
               if (byte_done) begin
                  data_q <= byte_in;
                  phase  <= PH_STAT_TAIL;
               end
            end
            PH_WEN_TAIL,
            PH_STAT_TAIL: phase <= PH_DISCARD;
            PH_READOUT,
            PH_DISCARD:   phase <= phase;
            default:      phase <= PH_DISCARD;
         endcase
      end
   end

   // requests are taken from the phase held at the moment select rises
   assign wren_req  = sel_rise && (phase == PH_WEN_TAIL);
   assign wrsr_req  = sel_rise && (phase == PH_STAT_TAIL);
   assign wrsr_data = data_q;

   // transmit: a fresh status snapshot at each byte boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= 1'b0;
         snap   <= '0;
      end else if (sel_n_s) begin
         dout_q <= 1'b0;
      end else if (sclk_fall && phase == PH_READOUT) begin
         if (bit_idx == '0) begin
            snap   <= status_byte;
            dout_q <= status_byte[BYTE_W-1];
         end else begin
            dout_q <= snap[LAST_IDX - bit_idx];
         end
      end
   end

   assign dout = dout_q;

   AST_DOUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_q) |-> $past(sclk_fall || sel_n_s)) else $error("dout moved off a falling edge"); // R7

   AST_SILENT_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n_s && $past(sel_n_s)) |-> !dout_q) else $error("dout active while deselected"); // R7

endmodule

// File: rtl/fsp_busy_timer.sv
module fsp_busy_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

   initial begin
      assert (CYCLES >= 1) else $error("fsp_busy_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOAD) else $error("busy counter out of range"); // R6

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)) else $error("busy rose without a start"); // R6

endmodule

// File: rtl/fsp_status.sv
module fsp_status
   import fsp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              guard_n_s,
   input  logic              sel_rise,
   input  logic              wren_req,
   input  logic              wrsr_req,
   input  logic              new_lock,
   input  logic [1:0]        new_bp,
   input  logic              busy,
   output logic              commit,
   output logic              wel,
   output prot_t             prot,
   output logic [BYTE_W-1:0] status_byte
);

   logic hw_protected;

   assign hw_protected = prot.lock & ~guard_n_s;
   assign commit       = wrsr_req & wel & ~hw_protected & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         prot <= '0;
      end else if (commit) begin
         wel       <= 1'b0;
         prot.lock <= new_lock;
         prot.bp   <= new_bp;
      end else if (wren_req && !busy) begin
         wel <= 1'b1;
      end
   end

   always_comb begin
      status_byte           = '0;
      status_byte[POS_LOCK] = prot.lock;
      status_byte[POS_BP1]  = prot.bp[1];
      status_byte[POS_BP0]  = prot.bp[0];
      status_byte[POS_WEL]  = wel;
      status_byte[POS_BUSY] = busy;
   end

   AST_WEL_SET_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(sel_rise)) else $error("latch set away from select rise"); // R2

   AST_PROT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot) |-> $past(wel)) else $error("protect fields moved without latch"); // R3

   AST_WEL_DROPS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel) else $error("latch still set in busy cycle"); // R6

   AST_HPM_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (prot.lock && !guard_n_s && wrsr_req) |=> $stable(prot)) else $error("write passed hardware protect"); // R8

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wrsr_req || wren_req)) |=> ($stable(prot) && $stable(wel))) else $error("command accepted while busy"); // R10

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
   import fsp_pkg::*;
#(
   parameter int WRITE_CYCLES = 1000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sel_n,
   input  logic       spi_clk,
   input  logic       spi_din,
   input  logic       wr_guard_n,
   output logic       spi_dout,
   output logic       write_busy,
   output logic       wr_enabled,
   output logic [1:0] blk_prot,
   output logic       sr_lock
);

   localparam logic [3:0] PIN_RST = 4'b1001;

   logic [3:0]        pins_s;
   logic              sel_n_s, sclk_s, din_s, guard_n_s;
   logic              sel_rise, wren_req, wrsr_req, commit, busy, wel;
   logic [BYTE_W-1:0] wrsr_data, status_byte;
   prot_t             prot;

   fsp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) sync_i (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({spi_sel_n, spi_clk, spi_din, wr_guard_n}),
      .q   (pins_s)
   );

   assign {sel_n_s, sclk_s, din_s, guard_n_s} = pins_s;

   fsp_frame frame_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_n_s     (sel_n_s),
      .sclk_s      (sclk_s),
      .din_s       (din_s),
      .status_byte (status_byte),
      .dout        (spi_dout),
      .sel_rise    (sel_rise),
      .wren_req    (wren_req),
      .wrsr_req    (wrsr_req),
      .wrsr_data   (wrsr_data)
   );

   fsp_status status_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .guard_n_s   (guard_n_s),
      .sel_rise    (sel_rise),
      .wren_req    (wren_req),
      .wrsr_req    (wrsr_req),
      .new_lock    (wrsr_data[POS_LOCK]),
      .new_bp      ({wrsr_data[POS_BP1], wrsr_data[POS_BP0]}),
      .busy        (busy),
      .commit      (commit),
      .wel         (wel),
      .prot        (prot),
      .status_byte (status_byte)
   );

   fsp_busy_timer #(.CYCLES(WRITE_CYCLES)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit),
      .busy  (busy)
   );

   assign write_busy = busy;
   assign wr_enabled = wel;
   assign blk_prot   = prot.bp;
   assign sr_lock    = prot.lock;

endmodule

// File: tb/flash_status_ctrl_tb.sv
module flash_status_ctrl_tb_top;

   localparam int CYC  = 600;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sel_n = 1'b1, spi_clk = 1'b0, spi_din = 1'b0, wr_guard_n = 1'b1;
   logic       spi_dout, write_busy, wr_enabled, sr_lock;
   logic [1:0] blk_prot;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   flash_status_ctrl #(.WRITE_CYCLES(CYC), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_clk(spi_clk),
      .spi_din(spi_din), .wr_guard_n(wr_guard_n), .spi_dout(spi_dout),
      .write_busy(write_busy), .wr_enabled(wr_enabled), .blk_prot(blk_prot),
      .sr_lock(sr_lock)
   );

   // vector: {wren_first, mode(0 exact,1 extra bit,2 short), guard_n, data, expected status}
   localparam logic [19:0] VEC [0:7] = '{
      {1'b1, 2'd0, 1'b1, 8'hFF, 8'h8C},
      {1'b0, 2'd0, 1'b1, 8'h00, 8'h8C},
      {1'b1, 2'd1, 1'b1, 8'h04, 8'h8E},
      {1'b1, 2'd2, 1'b1, 8'h04, 8'h8E},
      {1'b1, 2'd0, 1'b1, 8'h77, 8'h04},
      {1'b1, 2'd0, 1'b1, 8'h80, 8'h80},
      {1'b1, 2'd0, 1'b0, 8'h0C, 8'h82},
      {1'b1, 2'd0, 1'b1, 8'h0C, 8'h0C}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic spi_bit(input logic b, output logic rx);
      spi_din = b;
      tick(HALF);
      rx = spi_dout;
      spi_clk = 1'b1;
      tick(HALF);
      spi_clk = 1'b0;
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - n; i--) begin
         logic r;
         spi_bit(tx[i], r);
         rx[i] = r;
      end
   endtask

   task automatic sel_lo();
      spi_sel_n = 1'b0;
      tick(4);
   endtask

   task automatic sel_hi();
      tick(4);
      spi_sel_n = 1'b1;
      tick(8);
   endtask

   task automatic wren_frame();
      logic [7:0] r;
      sel_lo(); spi_bits(8'h06, 8, r); sel_hi();
   endtask

   task automatic wrsr_frame(input logic [7:0] d, input int mode);
      logic [7:0] r;
      logic       x;
      sel_lo();
      spi_bits(8'h01, 8, r);
      spi_bits(d, (mode == 2) ? 7 : 8, r);
      if (mode == 1) spi_bit(1'b0, x);
      sel_hi();
   endtask

   task automatic read_status(input int nbytes, output logic [7:0] b0, output logic [7:0] b1);
      logic [7:0] r;
      sel_lo();
      spi_bits(8'h05, 8, r);
      spi_bits(8'h00, 8, b0);
      b1 = b0;
      if (nbytes > 1) spi_bits(8'h00, 8, b1);
      sel_hi();
   endtask

   function automatic logic [7:0] port_status();
      return {sr_lock, 3'b000, blk_prot, wr_enabled, write_busy};
   endfunction

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] b0, b1, r;
      int ref_cyc;
      tick(5);
      // R1 reset state
      check("R1 status", {24'd0, port_status()}, 32'h00);
      check("R1 dout", {31'd0, spi_dout}, 32'd0);
      rst_n = 1'b1;
      tick(5);
      check("R1 after release", {24'd0, port_status()}, 32'h00);

      // R9 unknown opcode poisons the frame
      sel_lo(); spi_bits(8'hAA, 8, r); spi_bits(8'h06, 8, r); sel_hi();
      check("R9 latch after bad opcode", {31'd0, wr_enabled}, 32'd0);

      // R2 write enable framing
      sel_lo(); spi_bits(8'h06, 8, r); spi_bits(8'h80, 1, r); sel_hi();
      check("R2 extra bit", {31'd0, wr_enabled}, 32'd0);
      wren_frame();
      check("R2 exact frame", {31'd0, wr_enabled}, 32'd1);

      // table walk: R3 R4 R5 R8
      for (int i = 0; i < 8; i++) begin
         logic [19:0] v;
         v = VEC[i];
         wr_guard_n = v[16];
         tick(4);
         if (v[19]) wren_frame();
         wrsr_frame(v[15:8], int'(v[18:17]));
         tick(CYC + 20);
         check($sformatf("R3 R4 R5 R8 vector %0d ports", i), {24'd0, port_status()}, {24'd0, v[7:0]});
         read_status(1, b0, b1);
         check($sformatf("R7 vector %0d readback", i), {24'd0, b0}, {24'd0, v[7:0]});
      end
      wr_guard_n = 1'b1;
      tick(4);

      // R6 busy period, R7 readback while busy, R10 commands ignored while busy
      wren_frame();
      sel_lo(); spi_bits(8'h01, 8, r); spi_bits(8'h80, 8, r);
      tick(4);
      spi_sel_n = 1'b1;
      ref_cyc = cyc;
      tick(10);
      check("R6 busy after commit", {31'd0, write_busy}, 32'd1);
      check("R6 latch cleared", {31'd0, wr_enabled}, 32'd0);
      read_status(2, b0, b1);
      check("R7 read during busy", {24'd0, b0}, 32'h81);
      check("R7 repeated byte", {24'd0, b1}, 32'h81);
      wren_frame();
      check("R10 enable ignored while busy", {31'd0, wr_enabled}, 32'd0);
      while (cyc < ref_cyc + CYC - 10) tick(1);
      check("R6 still busy near end", {31'd0, write_busy}, 32'd1);
      while (cyc < ref_cyc + CYC + 20) tick(1);
      check("R6 busy ended", {31'd0, write_busy}, 32'd0);
      check("R10 fields kept", {24'd0, port_status()}, 32'h80);
      check("R7 dout low deselected", {31'd0, spi_dout}, 32'd0);

      finish_run();
   end

endmodule